// File: doc/BRIEF.md
# Minute-Resolution Alarm Comparator

This block watches the running calendar time and raises an alarm when the programmed alarm time arrives. It compares four alarm fields against the current BCD time fields supplied by a calendar counter. The fields are minute, hour, day of month and day of week. Seconds take no part in the comparison, so the alarm resolves only to the minute. Each alarm field can be switched out of the comparison independently. This allows patterns such as "every hour at minute 30" or "every day at 07:15".

Software programs the block through a simple byte-write port. Four alarm registers hold the target values. A control byte holds the interrupt enable. A status byte holds the alarm flag, and writing a zero to the flag position clears it.

The calendar counter pulses a strobe once per minute, in the cycle where the seconds count rolls over to 00. The comparison is evaluated only on that strobe. A qualifying minute therefore sets the flag exactly once. The flag drives an active-low interrupt line while the interrupt enable is also set.

Top module: `almcmp_top`

## Requirements
- R1: After reset, alarm_flag is 0, irq_n is 1, the interrupt enable is 0, and every alarm field is excluded from the comparison (alarm registers reset to 8'h80).
- R2: The alarm registers are written at byte addresses 8'h0A (minute), 8'h0B (hour), 8'h0C (date) and 8'h0D (weekday). In each one, bit 7 is an active-low field enable: 0 includes the field and 1 excludes it.
- R3: Only bits 6:0 of the minute register, bits 5:0 of the hour and date registers, and bits 2:0 of the weekday register are compared. The remaining bits below bit 7 never affect a match.
- R4: A comparison is made only in a cycle where sec_roll is 1. alarm_flag becomes 1 at the clock edge that samples the matching strobe. Matching time fields without the strobe never set the flag.
- R5: On a strobe, the flag is set when every included field equals its current time field. Any included field that differs prevents the set. Excluded fields are not considered.
- R6: When all four fields are excluded, a strobe never sets the flag, whatever the time fields hold.
- R7: Once set, alarm_flag stays 1 until a write to address 8'h01 with data bit 3 equal to 0. A write to 8'h01 with bit 3 equal to 1 neither sets nor clears the flag.
- R8: When a matching strobe and a clearing write occur in the same cycle, the flag ends up set.
- R9: The interrupt enable is bit 1 of the byte at address 8'h00. irq_n is 0 exactly while alarm_flag is 1 and the enable is 1, and it follows those registered values in the same cycle.
- R10: Writes to any other address change neither the alarm fields, the enable nor the flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 8 | Register write address |
| wr_data | input | 8 | Register write data |
| sec_roll | input | 1 | One-cycle pulse when seconds roll to 00 |
| cur_min | input | 7 | Current minute, BCD |
| cur_hour | input | 6 | Current hour, BCD |
| cur_date | input | 6 | Current day of month, BCD |
| cur_wday | input | 3 | Current day of week |
| alarm_flag | output | 1 | Sticky alarm status |
| irq_n | output | 1 | Active-low alarm interrupt |

## Verification
The hardest cases to reach combine a partial field selection with a mismatch confined to an excluded field. Such a combination must still raise the alarm, while a single mismatch in an included field must block it. The stimulus sweeps all sixteen enable combinations against all sixteen per-field mismatch patterns. Each sweep step writes stray upper bits into the alarm registers, so the field-width rule is exercised on the way. A separate step lines up a matching strobe with a clearing write in the same cycle to show which one wins.

// File: rtl/almcmp_pkg.sv
package almcmp_pkg;

  localparam int NFIELD = 4;
  localparam int BYTE_W = 8;
  localparam int EN_BIT = 7;

  typedef enum logic [1:0] {
    FLD_MIN  = 2'd0,
    FLD_HOUR = 2'd1,
    FLD_DATE = 2'd2,
    FLD_WDAY = 2'd3
  } fld_e;

  // Bits of each alarm register that take part in the comparison
  function automatic logic [BYTE_W-1:0] fld_mask(input int idx);
    case (idx)
      0:       fld_mask = 8'h7F;
      1, 2:    fld_mask = 8'h3F;
      default: fld_mask = 8'h07;
    endcase
  endfunction

  // Enable is active low in the top bit
  function automatic logic fld_included(input logic [BYTE_W-1:0] r);
    fld_included = ~r[EN_BIT];
  endfunction

  function automatic logic fld_equal(input logic [BYTE_W-1:0] alarm,
                                     input logic [BYTE_W-1:0] cur,
                                     input logic [BYTE_W-1:0] mask);
    fld_equal = ((alarm ^ cur) & mask) == '0;
  endfunction

endpackage

// File: rtl/almcmp_regs.sv
module almcmp_regs
  import almcmp_pkg::*;
#(
  parameter int ADDR_W     = 8,
  parameter int ALARM_BASE = 'h0A,
  parameter int CTRL_ADDR  = 'h00,
  parameter int STAT_ADDR  = 'h01,
  parameter int IEN_BIT    = 1,
  parameter int FLAG_BIT   = 3
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          wr_en,
  input  logic [ADDR_W-1:0]             wr_addr,
  input  logic [BYTE_W-1:0]             wr_data,
  output logic [NFIELD-1:0][BYTE_W-1:0] alarm_regs,
  output logic                          ien,
  output logic                          clr_req
);

  localparam logic [ADDR_W-1:0] CTRL_A = ADDR_W'(CTRL_ADDR);
  localparam logic [ADDR_W-1:0] STAT_A = ADDR_W'(STAT_ADDR);
  localparam logic [BYTE_W-1:0] OFF_VAL = BYTE_W'(1) << EN_BIT;

  for (genvar i = 0; i < NFIELD; i++) begin : g_field
    localparam logic [ADDR_W-1:0] FA = ADDR_W'(ALARM_BASE + i);
    logic sel;
    assign sel = wr_en && (wr_addr == FA);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   alarm_regs[i] <= OFF_VAL;
      else if (sel) alarm_regs[i] <= wr_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                            ien <= 1'b0;
    else if (wr_en && (wr_addr == CTRL_A)) ien <= wr_data[IEN_BIT];
  end

  assign clr_req = wr_en && (wr_addr == STAT_A) && !wr_data[FLAG_BIT];

  // R10
  other_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr != CTRL_A) |=> $stable(ien));

endmodule

// File: rtl/almcmp_cmp.sv
module almcmp_cmp
  import almcmp_pkg::*;
(
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [NFIELD-1:0][BYTE_W-1:0] alarm_regs,
  input  logic [NFIELD-1:0][BYTE_W-1:0] cur_fields,
  output logic [NFIELD-1:0]             incl_mask,
  output logic                          hit
);

  logic [NFIELD-1:0] fld_ok;

  for (genvar i = 0; i < NFIELD; i++) begin : g_cmp
    localparam logic [BYTE_W-1:0] M = fld_mask(i);
    assign incl_mask[i] = fld_included(alarm_regs[i]);
    assign fld_ok[i]    = !incl_mask[i] || fld_equal(alarm_regs[i], cur_fields[i], M);
  end

  assign hit = (incl_mask != '0) && (&fld_ok);

  // R6
  none_incl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (incl_mask == '0) |-> !hit);

endmodule

// File: rtl/almcmp_flag.sv
module almcmp_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic sec_roll,
  input  logic hit,
  input  logic clr_req,
  input  logic ien,
  output logic flag_q,
  output logic irq_n
);

  logic set_evt;
  assign set_evt = sec_roll && hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       flag_q <= 1'b0;
    else if (set_evt) flag_q <= 1'b1;
    else if (clr_req) flag_q <= 1'b0;
  end

  assign irq_n = !(flag_q && ien);

  // R4
  rise_on_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag_q) |-> $past(sec_roll));
  // R7
  sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_q && !clr_req) |=> flag_q);
  // R7
  fall_on_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(flag_q) |-> $past(clr_req));
  // R9
  irq_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !flag_q |-> irq_n);

endmodule

// File: rtl/almcmp_top.sv
module almcmp_top
  import almcmp_pkg::*;
#(
  parameter int ADDR_W     = 8,
  parameter int ALARM_BASE = 'h0A,
  parameter int CTRL_ADDR  = 'h00,
  parameter int STAT_ADDR  = 'h01,
  parameter int IEN_BIT    = 1,
  parameter int FLAG_BIT   = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [7:0]        wr_data,
  input  logic              sec_roll,
  input  logic [6:0]        cur_min,
  input  logic [5:0]        cur_hour,
  input  logic [5:0]        cur_date,
  input  logic [2:0]        cur_wday,
  output logic              alarm_flag,
  output logic              irq_n
);

  logic [NFIELD-1:0][BYTE_W-1:0] alarm_regs;
  logic [NFIELD-1:0][BYTE_W-1:0] cur_fields;
  logic [NFIELD-1:0]             incl_mask;
  logic                          ien;
  logic                          clr_req;
  logic                          hit;

  assign cur_fields[FLD_MIN]  = BYTE_W'(cur_min);
  assign cur_fields[FLD_HOUR] = BYTE_W'(cur_hour);
  assign cur_fields[FLD_DATE] = BYTE_W'(cur_date);
  assign cur_fields[FLD_WDAY] = BYTE_W'(cur_wday);

  almcmp_regs #(
    .ADDR_W(ADDR_W), .ALARM_BASE(ALARM_BASE), .CTRL_ADDR(CTRL_ADDR),
    .STAT_ADDR(STAT_ADDR), .IEN_BIT(IEN_BIT), .FLAG_BIT(FLAG_BIT)
  ) regs_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .alarm_regs(alarm_regs), .ien(ien), .clr_req(clr_req)
  );

  almcmp_cmp cmp_i (
    .clk(clk), .rst_n(rst_n), .alarm_regs(alarm_regs), .cur_fields(cur_fields),
    .incl_mask(incl_mask), .hit(hit)
  );

  almcmp_flag flag_i (
    .clk(clk), .rst_n(rst_n), .sec_roll(sec_roll), .hit(hit),
    .clr_req(clr_req), .ien(ien), .flag_q(alarm_flag), .irq_n(irq_n)
  );

  // R5 and R8: a matching strobe always leaves the flag set
  match_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sec_roll && hit) |=> alarm_flag);
  // R9
  irq_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (alarm_flag && ien) |-> !irq_n);

endmodule

// File: tb/almcmp_top_tb_top.sv
module almcmp_top_tb_top;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic       sec_roll = 1'b0;
  logic [6:0] cur_min = '0;
  logic [5:0] cur_hour = '0;
  logic [5:0] cur_date = '0;
  logic [2:0] cur_wday = '0;
  logic       alarm_flag;
  logic       irq_n;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  almcmp_top dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .sec_roll(sec_roll), .cur_min(cur_min),
    .cur_hour(cur_hour), .cur_date(cur_date), .cur_wday(cur_wday),
    .alarm_flag(alarm_flag), .irq_n(irq_n)
  );

  task automatic check(input logic got, input logic exp, input string req);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %0b expected %0b", req, got, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic strobe();
    @(negedge clk);
    sec_roll = 1'b1;
    @(negedge clk);
    sec_roll = 1'b0;
  endtask

  task automatic set_time(input logic [6:0] mi, input logic [5:0] hr,
                          input logic [5:0] dt, input logic [2:0] wd);
    cur_min = mi; cur_hour = hr; cur_date = dt; cur_wday = wd;
  endtask

  initial begin
    #1000000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(alarm_flag, 1'b0, "R1 flag after reset");
    check(irq_n, 1'b1, "R1 irq_n after reset");
    set_time(7'h00, 6'h00, 6'h00, 3'd0);
    strobe();
    check(alarm_flag, 1'b0, "R1 fields excluded after reset");

    // R2 R3 R5 R6 sweep: enable mask m, mismatch pattern p
    for (int m = 0; m < 16; m++) begin
      for (int p = 0; p < 16; p++) begin
        int k;
        logic [6:0] am; logic [5:0] ah, ad; logic [2:0] aw;
        logic exp;
        k  = m * 16 + p;
        am = 7'(k) ^ 7'h15;
        ah = 6'(k % 24);
        ad = 6'((k % 31) + 1);
        aw = 3'(k % 7);
        wr(8'h0A, {~m[0], am});
        wr(8'h0B, {~m[1], k[0], ah});
        wr(8'h0C, {~m[2], k[1], ad});
        wr(8'h0D, {~m[3], 4'(k >> 2), aw});
        wr(8'h01, 8'h00);
        set_time(p[0] ? am ^ 7'h40 : am,
                 p[1] ? ah ^ 6'h01 : ah,
                 p[2] ? ad ^ 6'h20 : ad,
                 p[3] ? aw ^ 3'h4 : aw);
        exp = (m != 0) && ((m & p) == 0);
        strobe();
        if (m == 0) check(alarm_flag, exp, "R6 all excluded");
        else if (p == 0) check(alarm_flag, exp, "R2 R3 full match");
        else check(alarm_flag, exp, "R5 per-field match");
      end
    end

    // R4: matching time without strobe does nothing
    wr(8'h0A, 8'h30); wr(8'h0B, 8'h07); wr(8'h0C, 8'h80); wr(8'h0D, 8'h80);
    wr(8'h01, 8'h00);
    set_time(7'h30, 6'h07, 6'h11, 3'd2);
    repeat (5) @(negedge clk);
    check(alarm_flag, 1'b0, "R4 no strobe no set");
    strobe();
    check(alarm_flag, 1'b1, "R4 strobe sets");

    // R7: sticky, write with bit3=1 keeps, change of time keeps
    set_time(7'h31, 6'h07, 6'h11, 3'd2);
    strobe();
    check(alarm_flag, 1'b1, "R7 sticky over mismatch");
    wr(8'h01, 8'h08);
    check(alarm_flag, 1'b1, "R7 write one keeps flag");
    // R10: other addresses leave flag and fields alone
    wr(8'h02, 8'h00);
    wr(8'h1A, 8'h00);
    check(alarm_flag, 1'b1, "R10 other address keeps flag");
    wr(8'h01, 8'hF7);
    check(alarm_flag, 1'b0, "R7 write zero clears");
    wr(8'h01, 8'h08);
    check(alarm_flag, 1'b0, "R7 write one does not set");
    set_time(7'h30, 6'h07, 6'h11, 3'd2);
    strobe();
    check(alarm_flag, 1'b1, "R10 alarm fields unchanged");

    // R8: set beats clear
    wr(8'h01, 8'h00);
    @(negedge clk);
    sec_roll = 1'b1; wr_en = 1'b1; wr_addr = 8'h01; wr_data = 8'h00;
    @(negedge clk);
    sec_roll = 1'b0; wr_en = 1'b0;
    check(alarm_flag, 1'b1, "R8 set wins over clear");

    // R9: interrupt line
    check(irq_n, 1'b1, "R9 enable off");
    wr(8'h05, 8'h02);
    check(irq_n, 1'b1, "R10 stray enable write");
    wr(8'h00, 8'h02);
    check(irq_n, 1'b0, "R9 flag and enable");
    wr(8'h00, 8'hFD);
    check(irq_n, 1'b1, "R9 enable bit cleared");
    wr(8'h00, 8'h02);
    check(irq_n, 1'b0, "R9 enable again");
    wr(8'h01, 8'h00);
    check(irq_n, 1'b1, "R9 flag cleared");
    strobe();
    check(irq_n, 1'b0, "R9 new alarm asserts");

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule